// File: doc/BRIEF.md
# Interrupt Group Register Bank

This block holds the interrupt state for one group of up to 32 event sources. Each source raises a one-cycle pulse on its own bit of the event vector. If that source is not masked at that moment, the pulse is captured in a sticky identity register. Software sees and controls the group through four word registers on a small memory-mapped bus. It reads the raw event lines, masks sources at capture time, acknowledges captured events by writing ones, and picks which captured events are forwarded.

The forwarded result is a bitwise pending vector, identity AND enable. An upper aggregation stage combines it with other groups. The mask is applied when an event arrives, so a masked pulse is lost for good. The enable register only decides what is forwarded upward and never changes what is captured.

Top module: `irq_group_bank`

## Requirements
- R1: Byte offsets on `bus_addr` select the registers: 0x0 = status, 0x4 = mask, 0x8 = identity, 0xC = enable.
- R2: After reset, identity and enable are all zeros, mask is all ones, and `pending` is zero.
- R3: An event pulse on bit b sets identity bit b when mask bit b is 0 in that cycle. The bit then stays set until software clears it.
- R4: An event pulse on a bit whose mask bit is 1 does not change identity. Unmasking the bit later does not recover the pulse.
- R5: A write to identity clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R6: If an event sets an identity bit in the same cycle as a write-one clears that bit, the bit ends up set.
- R7: A write to mask replaces the whole mask value and does not change identity.
- R8: A write to enable replaces the whole enable value.
- R9: `pending` equals identity AND enable, bit by bit. It reflects any write or event from the cycle after that clock edge.
- R10: A status read returns the event inputs present in the read cycle. A write to status changes no register.
- R11: Read data appears one cycle after the address. It carries the register value from before any write in the same cycle. An address outside the four offsets reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | WIDTH | One-cycle event pulse per source |
| bus_addr | input | ADDR_W | Byte address inside the group |
| bus_wdata | input | WIDTH | Write data |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_rdata | output | WIDTH | Registered read data, one cycle after the address |
| pending | output | WIDTH | Identity AND enable, toward the upper stage |

## Verification
The bench pulses a source while it is masked and then unmasks it. A design that queued masked events would then show a stale identity bit. It clears one identity bit with a write-one in the same cycle that the same bit fires. Giving the clear priority would lose the fresh event.

It also clears some identity bits while writing zeros to others. A design that treated the identity write as a plain store would wipe those zero-written bits. It changes enable and mask on their own, which exposes a pending output that forgot the enable gate or a mask write that disturbed identity. A write to status and reads from unused offsets catch a bank that decodes too loosely.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;

  localparam int unsigned OFS_STATUS = 'h0;
  localparam int unsigned OFS_MASK   = 'h4;
  localparam int unsigned OFS_IDENT  = 'h8;
  localparam int unsigned OFS_ENABLE = 'hC;

  typedef enum logic [2:0] {
    SEL_NONE   = 3'd0,
    SEL_STATUS = 3'd1,
    SEL_MASK   = 3'd2,
    SEL_IDENT  = 3'd3,
    SEL_ENABLE = 3'd4
  } reg_sel_e;

  // Capture vector: events that pass the current mask.
  function automatic logic [31:0] f_capture(input logic [31:0] evt,
                                            input logic [31:0] msk);
    return evt & ~msk;
  endfunction

  // Next identity value: write-one clear first, then fresh captures win.
  function automatic logic [31:0] f_ident_next(input logic [31:0] cur,
                                               input logic [31:0] clr,
                                               input logic [31:0] cap);
    return (cur & ~clr) | cap;
  endfunction

  // Forwarded pending level.
  function automatic logic [31:0] f_pending(input logic [31:0] idn,
                                            input logic [31:0] en);
    return idn & en;
  endfunction

endpackage

// File: rtl/irq_grp_decode.sv
module irq_grp_decode
  import irq_grp_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output reg_sel_e          sel,
  output logic              wr_mask,
  output logic              wr_ident,
  output logic              wr_enable
);

  always_comb begin
    if (addr == ADDR_W'(OFS_STATUS))      sel = SEL_STATUS;
    else if (addr == ADDR_W'(OFS_MASK))   sel = SEL_MASK;
    else if (addr == ADDR_W'(OFS_IDENT))  sel = SEL_IDENT;
    else if (addr == ADDR_W'(OFS_ENABLE)) sel = SEL_ENABLE;
    else                                  sel = SEL_NONE;
  end

  // Status has no write strobe: writes there are dropped.
  assign wr_mask   = we && (sel == SEL_MASK);
  assign wr_ident  = we && (sel == SEL_IDENT);
  assign wr_enable = we && (sel == SEL_ENABLE);

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_mask, wr_ident, wr_enable})); // R1

  AST_NO_WRITE_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !we |-> !(wr_mask || wr_ident || wr_enable)); // R10

endmodule

// File: rtl/irq_grp_ctrl_reg.sv
module irq_grp_ctrl_reg #(
  parameter int unsigned WIDTH     = 32,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RESET_VAL;
    else if (wr) q <= wdata;
  end

  AST_CTRL_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (q == $past(wdata))); // R7 R8

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q)); // R10

endmodule

// File: rtl/irq_grp_ident.sv
module irq_grp_ident
  import irq_grp_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] evt,
  input  logic [WIDTH-1:0] mask,
  input  logic             clr_en,
  input  logic [WIDTH-1:0] clr_data,
  output logic [WIDTH-1:0] ident,
  output logic [WIDTH-1:0] cap_vec,
  output logic [WIDTH-1:0] clr_vec
);

  localparam int unsigned PADW = 32 - WIDTH;

  logic [31:0] nxt32;

  assign cap_vec = WIDTH'(f_capture({{PADW{1'b0}}, evt}, {{PADW{1'b0}}, mask}));
  assign clr_vec = clr_en ? clr_data : '0;
  assign nxt32   = f_ident_next({{PADW{1'b0}}, ident},
                                {{PADW{1'b0}}, clr_vec},
                                {{PADW{1'b0}}, cap_vec});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ident <= '0;
    else        ident <= nxt32[WIDTH-1:0];
  end

  AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ident & ~$past(ident) & $past(mask)) == '0)); // R4

  AST_CAPTURE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ident & $past(cap_vec)) == $past(cap_vec))); // R3 R6

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((ident & $past(clr_vec & ~cap_vec)) == '0)); // R5

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((ident & $past(ident)) == $past(ident))); // R3

endmodule

// File: rtl/irq_grp_rdmux.sv
module irq_grp_rdmux
  import irq_grp_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] status,
  input  logic [WIDTH-1:0] mask,
  input  logic [WIDTH-1:0] ident,
  input  logic [WIDTH-1:0] enable,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mux;

  always_comb begin
    unique case (sel)
      SEL_STATUS: mux = status;
      SEL_MASK:   mux = mask;
      SEL_IDENT:  mux = ident;
      SEL_ENABLE: mux = enable;
      default:    mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mux;
  end

  AST_UNUSED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |=> (rdata == '0)); // R11

  AST_STATUS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_STATUS) |=> (rdata == $past(status))); // R10 R11

endmodule

// File: rtl/irq_group_bank.sv
module irq_group_bank
  import irq_grp_pkg::*;
#(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  evt_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic [WIDTH-1:0]  pending
);

  localparam int unsigned PADW = 32 - WIDTH;
  localparam logic [WIDTH-1:0] MASK_RST = '1;
  localparam logic [WIDTH-1:0] EN_RST   = '0;

  reg_sel_e         sel;
  logic             wr_mask, wr_ident, wr_enable;
  logic [WIDTH-1:0] mask_q, enable_q, ident_q;
  logic [WIDTH-1:0] cap_vec, clr_vec;
  logic [31:0]      pend32;

  irq_grp_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
    .sel(sel), .wr_mask(wr_mask), .wr_ident(wr_ident), .wr_enable(wr_enable)
  );

  irq_grp_ctrl_reg #(.WIDTH(WIDTH), .RESET_VAL(MASK_RST)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr(wr_mask), .wdata(bus_wdata), .q(mask_q)
  );

  irq_grp_ctrl_reg #(.WIDTH(WIDTH), .RESET_VAL(EN_RST)) u_enable (
    .clk(clk), .rst_n(rst_n), .wr(wr_enable), .wdata(bus_wdata), .q(enable_q)
  );

  irq_grp_ident #(.WIDTH(WIDTH)) u_ident (
    .clk(clk), .rst_n(rst_n), .evt(evt_i), .mask(mask_q),
    .clr_en(wr_ident), .clr_data(bus_wdata),
    .ident(ident_q), .cap_vec(cap_vec), .clr_vec(clr_vec)
  );

  irq_grp_rdmux #(.WIDTH(WIDTH)) u_rdmux (
    .clk(clk), .rst_n(rst_n), .sel(sel),
    .status(evt_i), .mask(mask_q), .ident(ident_q), .enable(enable_q),
    .rdata(bus_rdata)
  );

  assign pend32  = f_pending({{PADW{1'b0}}, ident_q}, {{PADW{1'b0}}, enable_q});
  assign pending = pend32[WIDTH-1:0];

  AST_PENDING_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending & ~enable_q) == '0) && ((pending & ~ident_q) == '0)); // R9

  AST_PENDING_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_enable && !wr_ident && (cap_vec == '0)) |=>
      (pending == ($past(ident_q) & $past(bus_wdata)))); // R8 R9

  AST_MASK_WRITE_KEEPS_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && (cap_vec == '0)) |=> $stable(ident_q)); // R7

  AST_CLEAR_ONLY_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ident |=> ((ident_q & $past(ident_q & ~clr_vec)) == $past(ident_q & ~clr_vec))); // R5

endmodule

// File: tb/irq_group_bank_bench.sv
`timescale 1ns/1ps
module irq_group_bank_bench;

  localparam int unsigned WIDTH  = 32;
  localparam int unsigned ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_STAT = 6'h00;
  localparam logic [ADDR_W-1:0] A_MASK = 6'h04;
  localparam logic [ADDR_W-1:0] A_IDN  = 6'h08;
  localparam logic [ADDR_W-1:0] A_EN   = 6'h0C;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [WIDTH-1:0]  evt_i = '0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [WIDTH-1:0]  bus_wdata = '0;
  logic              bus_we = 1'b0;
  logic [WIDTH-1:0]  bus_rdata;
  logic [WIDTH-1:0]  pending;

  int n_checks = 0;
  int n_fail   = 0;
  logic rd_req = 1'b0;
  logic armed  = 1'b0;
  logic [WIDTH-1:0] exp_q[$];
  string            tag_q[$];

  always #2.5 clk = ~clk;

  irq_group_bank #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_irq_group_bank (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata), .pending(pending)
  );

  task automatic check(input string tag, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one bus/event cycle; a read pushes its expected value to the scoreboard.
  task automatic cyc(input logic [ADDR_W-1:0] a, input logic we, input logic [WIDTH-1:0] d,
                     input logic [WIDTH-1:0] ev, input logic rd,
                     input logic [WIDTH-1:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = d; evt_i = ev; rd_req = rd;
    if (rd) begin exp_q.push_back(exp); tag_q.push_back(tag); end
  endtask

  task automatic idle();
    cyc('0, 1'b0, '0, '0, 1'b0, '0, "");
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [WIDTH-1:0] d);
    cyc(a, 1'b1, d, '0, 1'b0, '0, "");
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [WIDTH-1:0] exp, input string tag);
    cyc(a, 1'b0, '0, '0, 1'b1, exp, tag);
  endtask

  task automatic pulse(input logic [WIDTH-1:0] ev);
    cyc('0, 1'b0, '0, ev, 1'b0, '0, "");
  endtask

  task automatic chk_pend(input logic [WIDTH-1:0] exp, input string tag);
    idle();
    check(tag, pending, exp);
  endtask

  // Monitor: compares read data one cycle after the read address.
  always @(posedge clk) armed <= rd_req;
  always @(negedge clk) begin
    if (armed) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R11: unexpected read result %h expected none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    chk_pend('0, "R2 pending after reset");
    rd(A_MASK, 32'hFFFF_FFFF, "R2 mask reset all ones");
    rd(A_IDN,  32'h0, "R2 identity reset");
    rd(A_EN,   32'h0, "R2 enable reset");
    // R4 masked pulse dropped
    pulse(32'h0000_0001);
    rd(A_IDN, 32'h0, "R4 masked event not captured");
    // R7 mask replace
    wr(A_MASK, 32'h0000_00F0);
    rd(A_MASK, 32'h0000_00F0, "R7 mask write");
    wr(A_MASK, 32'hFFFF_0F0F);
    rd(A_MASK, 32'hFFFF_0F0F, "R7 mask replaced whole");
    rd(A_IDN, 32'h0, "R4 unmask does not recover dropped event");
    // R8 enable replace
    wr(A_EN, 32'h0000_00FF);
    rd(A_EN, 32'h0000_00FF, "R8 enable write");
    // R3 capture of unmasked bits only
    pulse(32'h0000_00F3);
    rd(A_IDN, 32'h0000_00F0, "R3 unmasked events captured");
    chk_pend(32'h0000_00F0, "R9 pending identity and enable");
    pulse(32'h0000_3000);
    chk_pend(32'h0000_00F0, "R9 not-enabled bits not forwarded");
    rd(A_IDN, 32'h0000_30F0, "R3 captured bits sticky");
    wr(A_EN, 32'h0000_F0F0);
    chk_pend(32'h0000_30F0, "R9 pending follows enable write");
    // R5 write-one-to-clear
    wr(A_IDN, 32'h0000_1030);
    rd(A_IDN, 32'h0000_20C0, "R5 write one clears only ones");
    chk_pend(32'h0000_20C0, "R9 pending after clear");
    // R6 set wins over clear
    cyc(A_IDN, 1'b1, 32'h0000_00C0, 32'h0000_0040, 1'b0, '0, "");
    rd(A_IDN, 32'h0000_2040, "R6 same-cycle event beats clear");
    // R10 status
    cyc(A_STAT, 1'b0, '0, 32'hA5A5_0000, 1'b1, 32'hA5A5_0000, "R10 status shows live events");
    rd(A_STAT, 32'h0, "R10 status idle");
    wr(A_STAT, 32'h1234_5678);
    rd(A_MASK, 32'hFFFF_0F0F, "R10 status write leaves mask");
    rd(A_IDN,  32'h0000_2040, "R10 status write leaves identity");
    rd(A_EN,   32'h0000_F0F0, "R10 status write leaves enable");
    // R11 unused offsets
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h10, 32'h0, "R11 unused offset reads zero");
    rd(6'h3C, 32'h0, "R11 high unused offset reads zero");
    rd(A_IDN, 32'h0000_2040, "R11 write to unused offset changes nothing");
    // R11 read returns value before same-cycle write
    cyc(A_EN, 1'b1, 32'h0000_2000, '0, 1'b1, 32'h0000_F0F0, "R11 read sees pre-write value");
    rd(A_EN, 32'h0000_2000, "R8 enable replaced");
    // R7 mask write leaves identity
    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_IDN, 32'h0000_2040, "R7 mask write keeps identity");
    chk_pend(32'h0000_2000, "R9 pending after enable change");
    // R1 offsets distinct
    wr(A_EN, 32'h0);
    chk_pend(32'h0, "R9 enable zero blocks pending");
    rd(A_MASK, 32'hFFFF_FFFF, "R1 mask offset");
    repeat (3) idle();
    if (exp_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R11: actual %0d reads outstanding expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule